// File: doc/BRIEF.md
# Last-Outcome Branch Target Buffer

This block predicts the next fetch address for a branch. It holds a small set of fully associative entries. Each entry records a branch address, the direction that branch took the last time it resolved, and the target address computed at that resolution. The fetch stage presents its current address and receives a hit flag, a predicted-taken flag and the next fetch address in the same cycle. No register lies on the lookup path.

When a branch resolves, the execute side presents the branch address, the actual outcome and the computed target on the update port. An address that is already held has its entry rewritten. An address that is not held takes a free slot. The new contents are visible to lookups from the following cycle. The first encounter of a branch always misses, so fetch falls through and the branch is effectively predicted not-taken. After that, every prediction repeats the last resolved outcome. There is no hysteresis and no replacement. Jump and jump-and-link resolutions are flagged on the update port and never enter the buffer.

Top module: `btb_last_outcome`

## Requirements
- R1: While reset is asserted and right after it, no entry is valid. Every lookup misses, and next_pc_o equals fetch_pc_i + 4.
- R2: hit_o, pred_taken_o and next_pc_o follow fetch_pc_i combinationally, within the same cycle and with no clock edge.
- R3: On a miss, hit_o=0, pred_taken_o=0 and next_pc_o = fetch_pc_i + 4.
- R4: On a hit whose recorded outcome is taken, hit_o=1, pred_taken_o=1 and next_pc_o is the stored target.
- R5: On a hit whose recorded outcome is not-taken, hit_o=1, pred_taken_o=0 and next_pc_o = fetch_pc_i + 4.
- R6: An accepted update (upd_valid_i=1, upd_is_jump_i=0) for an absent address creates an entry when a slot is free. The entry holds upd_taken_i and upd_target_i. Lookups in the same cycle still see the old contents, and lookups from the next cycle see the new entry.
- R7: An accepted update for an address already held overwrites that entry's outcome and target and uses no further slot.
- R8: The prediction equals the most recent resolved outcome alone. A single opposite outcome flips it.
- R9: When all ENTRIES (default 8) slots are valid, an update for an absent address is dropped and the existing entries are unchanged. Updates to held addresses still apply.
- R10: An update with upd_is_jump_i=1 writes nothing.
- R11: Matching compares every bit of the address. An address that differs in any bit from a stored one misses.
- R12: With upd_valid_i=0 the update inputs have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| fetch_pc_i | input | 32 | Address being fetched |
| hit_o | output | 1 | A valid entry matches fetch_pc_i |
| pred_taken_o | output | 1 | Hit with recorded outcome taken |
| next_pc_o | output | 32 | Predicted next fetch address |
| upd_valid_i | input | 1 | Resolution present this cycle |
| upd_is_jump_i | input | 1 | Resolution is an unconditional jump (ignored) |
| upd_pc_i | input | 32 | Resolved branch address |
| upd_taken_i | input | 1 | Actual outcome, 1 = taken |
| upd_target_i | input | 32 | Computed target address |

## Verification
The bench targets the update-to-lookup boundary. A design that forwards updates early would hit in the same cycle, and one with an extra write register would still miss a cycle later. It flips a branch's outcome taken, not-taken, taken to expose any hidden hysteresis counter. It fills the buffer and then offers a ninth address: a design that replaced an entry would lose an earlier branch, and one that allocated twice on rewrites would run out of slots early. Jump-flagged and invalid updates, addresses that differ in the top or bottom bit, and a reset in mid-run are each checked at the outputs.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int unsigned BTB_ADDR_W      = 32;
  localparam int unsigned BTB_INSTR_BYTES = 4;

  typedef logic [BTB_ADDR_W-1:0] addr_t;

  typedef struct packed {
    logic  vld;
    logic  tkn;
    addr_t tag;
    addr_t tgt;
  } btb_ent_t;
endpackage

// File: rtl/btb_cam.sv
module btb_cam
  import btb_pkg::*;
#(
  parameter int unsigned ENTRIES = 8
) (
  input  btb_ent_t [ENTRIES-1:0] ent_i,
  input  addr_t                  key_i,
  output logic [ENTRIES-1:0]     match_o
);
  for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
    assign match_o[g] = ent_i[g].vld && (ent_i[g].tag == key_i);
  end
endmodule

// File: rtl/btb_free_pick.sv
module btb_free_pick #(
  parameter int unsigned ENTRIES = 8
) (
  input  logic [ENTRIES-1:0] vld_i,
  output logic [ENTRIES-1:0] grant_o,
  output logic               any_o
);
  // lowest-index invalid slot wins
  always_comb begin
    logic found;
    found   = 1'b0;
    grant_o = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (!vld_i[i] && !found) begin
        grant_o[i] = 1'b1;
        found      = 1'b1;
      end
    end
    any_o = found;
  end
endmodule

// File: rtl/btb_entry.sv
module btb_entry
  import btb_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     wr_i,
  input  btb_ent_t d_i,
  output btb_ent_t q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (wr_i) q_o <= d_i;
  end
endmodule

// File: rtl/btb_last_outcome.sv
module btb_last_outcome
  import btb_pkg::*;
#(
  parameter int unsigned ENTRIES = 8
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [31:0] fetch_pc_i,
  output logic        hit_o,
  output logic        pred_taken_o,
  output logic [31:0] next_pc_o,
  input  logic        upd_valid_i,
  input  logic        upd_is_jump_i,
  input  logic [31:0] upd_pc_i,
  input  logic        upd_taken_i,
  input  logic [31:0] upd_target_i
);
  localparam addr_t STEP = addr_t'(BTB_INSTR_BYTES);

  btb_ent_t [ENTRIES-1:0] ent_q;
  logic [ENTRIES-1:0]     lk_match, up_match, free_grant, wr_en, vld_vec;
  logic                   upd_hit, any_free, upd_acc;
  btb_ent_t               wr_data;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_vld
    assign vld_vec[g] = ent_q[g].vld;
  end

  btb_cam #(.ENTRIES(ENTRIES)) u_cam_lk (
    .ent_i(ent_q), .key_i(fetch_pc_i), .match_o(lk_match)
  );

  btb_cam #(.ENTRIES(ENTRIES)) u_cam_up (
    .ent_i(ent_q), .key_i(upd_pc_i), .match_o(up_match)
  );

  btb_free_pick #(.ENTRIES(ENTRIES)) u_pick (
    .vld_i(vld_vec), .grant_o(free_grant), .any_o(any_free)
  );

  assign upd_hit = |up_match;
  assign upd_acc = upd_valid_i && !upd_is_jump_i;
  assign wr_data = '{vld: 1'b1, tkn: upd_taken_i, tag: upd_pc_i, tgt: upd_target_i};
  // full and absent: free_grant is zero, write dropped
  assign wr_en   = upd_acc ? (upd_hit ? up_match : free_grant) : '0;

  for (genvar g = 0; g < ENTRIES; g++) begin : g_ent
    btb_entry u_ent (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .wr_i  (wr_en[g]),
      .d_i   (wr_data),
      .q_o   (ent_q[g])
    );
  end

  // and-or read; lk_match is one-hot0
  logic  rd_tkn;
  addr_t rd_tgt;
  always_comb begin
    rd_tkn = 1'b0;
    rd_tgt = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      rd_tkn = rd_tkn | (lk_match[i] & ent_q[i].tkn);
      rd_tgt = rd_tgt | ({BTB_ADDR_W{lk_match[i]}} & ent_q[i].tgt);
    end
  end

  assign hit_o        = |lk_match;
  assign pred_taken_o = rd_tkn;
  assign next_pc_o    = rd_tkn ? rd_tgt : fetch_pc_i + STEP;
endmodule

// File: rtl/btb_last_outcome_chk.sv
module btb_last_outcome_chk #(
  parameter int unsigned ENTRIES = 8
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [31:0]        fetch_pc_i,
  input logic               hit_o,
  input logic               pred_taken_o,
  input logic [31:0]        next_pc_o,
  input logic               upd_valid_i,
  input logic               upd_is_jump_i,
  input logic [31:0]        upd_pc_i,
  input logic               upd_taken_i,
  input logic [ENTRIES-1:0] lk_match,
  input logic [ENTRIES-1:0] vld_vec,
  input logic               upd_hit,
  input logic               any_free
);
  logic past_ok;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R4
  taken_needs_hit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pred_taken_o |-> hit_o);

  // R3
  miss_falls_through_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hit_o |-> (!pred_taken_o && next_pc_o == fetch_pc_i + 32'd4));

  // R7
  no_dup_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(lk_match));

  // R6
  update_visible_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(upd_valid_i && !upd_is_jump_i && (upd_hit || any_free))
     && fetch_pc_i == $past(upd_pc_i))
    |-> (hit_o && pred_taken_o == $past(upd_taken_i)));

  // R10
  jump_no_write_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(upd_valid_i && upd_is_jump_i)) |-> vld_vec == $past(vld_vec));

  // R9
  full_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(upd_valid_i && !upd_hit && !any_free))
    |-> $countones(vld_vec) == ENTRIES);
endmodule

bind btb_last_outcome btb_last_outcome_chk #(.ENTRIES(ENTRIES)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .fetch_pc_i   (fetch_pc_i),
  .hit_o        (hit_o),
  .pred_taken_o (pred_taken_o),
  .next_pc_o    (next_pc_o),
  .upd_valid_i  (upd_valid_i),
  .upd_is_jump_i(upd_is_jump_i),
  .upd_pc_i     (upd_pc_i),
  .upd_taken_i  (upd_taken_i),
  .lk_match     (lk_match),
  .vld_vec      (vld_vec),
  .upd_hit      (upd_hit),
  .any_free     (any_free)
);

// File: tb/btb_last_outcome_tb_top.sv
module btb_last_outcome_tb_top;
  localparam int CLK_P = 10;
  localparam int NV    = 13;

  typedef struct packed {
    logic        uv;
    logic        uj;
    logic [31:0] upc;
    logic        utk;
    logic [31:0] utg;
    logic [31:0] fpc;
    logic        eh;
    logic        et;
    logic [31:0] en;
    logic [7:0]  req;
  } vec_t;

  // uv uj upc utk utg | fpc | hit tkn next | req
  localparam vec_t VECS [NV] = '{
    '{1'b0, 1'b0, 32'h0,        1'b0, 32'h0,   32'h100,      1'b0, 1'b0, 32'h104,      8'd3},  // R3
    '{1'b1, 1'b0, 32'h100,      1'b1, 32'h400, 32'h100,      1'b0, 1'b0, 32'h104,      8'd6},  // R6 old view
    '{1'b0, 1'b0, 32'h0,        1'b0, 32'h0,   32'h100,      1'b1, 1'b1, 32'h400,      8'd4},  // R4
    '{1'b1, 1'b0, 32'h100,      1'b0, 32'h400, 32'h104,      1'b0, 1'b0, 32'h108,      8'd11}, // R11
    '{1'b0, 1'b0, 32'h0,        1'b0, 32'h0,   32'h100,      1'b1, 1'b0, 32'h104,      8'd5},  // R5 R8
    '{1'b1, 1'b0, 32'h100,      1'b1, 32'h800, 32'h100,      1'b1, 1'b0, 32'h104,      8'd8},  // R8
    '{1'b0, 1'b0, 32'h0,        1'b0, 32'h0,   32'h100,      1'b1, 1'b1, 32'h800,      8'd7},  // R7
    '{1'b1, 1'b1, 32'h200,      1'b1, 32'h900, 32'h200,      1'b0, 1'b0, 32'h204,      8'd10}, // R10
    '{1'b0, 1'b0, 32'h0,        1'b0, 32'h0,   32'h200,      1'b0, 1'b0, 32'h204,      8'd10}, // R10
    '{1'b0, 1'b0, 32'h300,      1'b1, 32'hA00, 32'h300,      1'b0, 1'b0, 32'h304,      8'd12}, // R12
    '{1'b0, 1'b0, 32'h0,        1'b0, 32'h0,   32'h300,      1'b0, 1'b0, 32'h304,      8'd12}, // R12
    '{1'b0, 1'b0, 32'h0,        1'b0, 32'h0,   32'h80000100, 1'b0, 1'b0, 32'h80000104, 8'd11}, // R11
    '{1'b0, 1'b0, 32'h0,        1'b0, 32'h0,   32'h101,      1'b0, 1'b0, 32'h105,      8'd11}  // R11
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] fetch_pc = '0;
  logic        hit, ptk;
  logic [31:0] npc;
  logic        uv = 1'b0, uj = 1'b0, utk = 1'b0;
  logic [31:0] upc = '0, utg = '0;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  btb_last_outcome dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fetch_pc_i(fetch_pc),
    .hit_o(hit), .pred_taken_o(ptk), .next_pc_o(npc),
    .upd_valid_i(uv), .upd_is_jump_i(uj), .upd_pc_i(upc),
    .upd_taken_i(utk), .upd_target_i(utg)
  );

  task automatic check(input int req, input logic eh, input logic et, input logic [31:0] en);
    total++;
    if (hit !== eh || ptk !== et || npc !== en) begin
      bad++;
      $display("FAIL R%0d: got hit=%0b tkn=%0b next=%h exp hit=%0b tkn=%0b next=%h",
               req, hit, ptk, npc, eh, et, en);
    end
  endtask

  task automatic step(input logic v, input logic j, input logic [31:0] p,
                      input logic t, input logic [31:0] g, input logic [31:0] f);
    @(negedge clk);
    uv = v; uj = j; upc = p; utk = t; utg = g; fetch_pc = f;
    #1;
  endtask

  task automatic finish_run();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    #(CLK_P * 100000);
    bad++; total++;
    $display("FAIL watchdog: got running exp finished");
    finish_run();
  end

  initial begin
    fetch_pc = 32'h40;
    #1;
    check(1, 1'b0, 1'b0, 32'h44); // R1 during reset
    repeat (2) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    #1;
    check(1, 1'b0, 1'b0, 32'h44); // R1 after release

    for (int k = 0; k < NV; k++) begin
      step(VECS[k].uv, VECS[k].uj, VECS[k].upc, VECS[k].utk, VECS[k].utg, VECS[k].fpc);
      check(int'(VECS[k].req), VECS[k].eh, VECS[k].et, VECS[k].en);
    end

    // R2: combinational response, no clock edge between
    step(1'b0, 1'b0, '0, 1'b0, '0, 32'h100);
    check(2, 1'b1, 1'b1, 32'h800);
    fetch_pc = 32'h500; #1;
    check(2, 1'b0, 1'b0, 32'h504);

    // R9: fill remaining 7 slots (0x100 already held)
    for (int i = 0; i < 7; i++)
      step(1'b1, 1'b0, 32'h1000 + 32'(i*4), 1'b1, 32'h2000 + 32'(i*16), 32'h0);
    step(1'b1, 1'b0, 32'h5000, 1'b1, 32'h6000, 32'h0);
    step(1'b0, 1'b0, '0, 1'b0, '0, 32'h5000);
    check(9, 1'b0, 1'b0, 32'h5004);
    fetch_pc = 32'h100; #1;
    check(9, 1'b1, 1'b1, 32'h800);
    fetch_pc = 32'h1018; #1;
    check(9, 1'b1, 1'b1, 32'h2060);
    // R7: rewrite of held address while full still applies
    step(1'b1, 1'b0, 32'h1000, 1'b0, 32'h2000, 32'h0);
    step(1'b0, 1'b0, '0, 1'b0, '0, 32'h1000);
    check(7, 1'b1, 1'b0, 32'h1004);

    // R1: reset mid-run clears everything
    @(negedge clk); rst_n = 1'b0; fetch_pc = 32'h100; #1;
    check(1, 1'b0, 1'b0, 32'h104);
    @(negedge clk); rst_n = 1'b1; #1;
    check(1, 1'b0, 1'b0, 32'h104);

    finish_run();
  end
endmodule